// File: doc/BRIEF.md
# Borrowed-Unit Majority Recovery Sequencer

This block supervises one function that normally runs on two identical functional units. It holds the operands in an operand register and feeds them to both units. Each cycle it compares the two results. When they agree, it commits the result to the output register at the next edge, so a fault-free operation adds no latency.

When the results differ, the block stalls the upstream stage in the same cycle and blocks the bad result. It then asks a neighbouring function to lend a third unit and keeps the operands frozen. With the grant present, it takes a bitwise two-of-three vote over the three results, commits the voted word, and releases the borrowed unit. The next operand enters the cycle after that, so recovery costs three extra cycles when the lender grants at once.

The block also serves as a lender. While a neighbour has taken its second unit, it commits the first unit's result without a comparison.

Top module: `borrow_vote_ctrl`

## Requirements
- R1: After reset, `outValid`, `stall`, `borrowReq` and `uncorrErr` are all 0.
- R2: When a valid operand's two native results are equal, `outValid` is 1 in the next cycle with `outData` equal to that result, and `stall` stays 0.
- R3: On a mismatch in idle, `stall` is 1 in that same cycle, and the disagreeing result is not committed (`outValid` is 0 in the next cycle).
- R4: In the first recovery cycle, `borrowReq` is 1 and `stall` is 1. `opOut` keeps the faulted operand. The sequence stays in this cycle until `borrowGnt` is 1.
- R5: In the vote cycle, which needs `borrowGnt`, the bitwise majority of `resA`, `resB` and `resC` is committed. `outValid` is 1 in the following cycle.
- R6: In the release cycle, `borrowReq` and `stall` are 0. The next operand is loaded at the end of that cycle, and `outValid` is 0 in the cycle after it.
- R7: If no two of the three results are equal as whole words, `uncorrErr` is a one-cycle pulse in the release cycle. `outValid` is 0 and `outData` keeps its previous value.
- R8: A mismatch that appears during recovery is ignored: `stall` stays 0 in the release cycle.
- R9: While `lendReq` is 1 in idle, a valid operand commits `resA` in the next cycle without a comparison, and `stall` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Upstream operand valid |
| inData | input | DATA_W | Upstream operand |
| stall | output | 1 | Upstream must hold its operand |
| opOut | output | DATA_W | Held operand driven to all units |
| resA | input | DATA_W | First native unit result |
| resB | input | DATA_W | Second native unit result |
| resC | input | DATA_W | Borrowed unit result |
| lendReq | input | 1 | Neighbour is borrowing this function's second unit |
| borrowReq | output | 1 | Request for the neighbour's unit |
| borrowGnt | input | 1 | Neighbour's unit is routed to `opOut` |
| outValid | output | 1 | Output register loaded this cycle |
| outData | output | DATA_W | Committed output register |
| uncorrErr | output | 1 | No majority was found during recovery |

## Verification
The checks assume three things about the inputs:
- The unit results settle combinationally from `opOut` within the same cycle.
- The upstream stage obeys `stall` by holding `inData` and `inValid`.
- `lendReq` never rises while this function is itself recovering.

The bench meets these assumptions by modelling the units as a fixed function of `opOut` with per-unit XOR fault masks. It acts as a compliant upstream stage that changes its operand only when `stall` is 0. It raises `lendReq` only in idle.

// File: rtl/bvc_pkg.sv
package bvc_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_BORROW  = 2'd1,
    PH_VOTE    = 2'd2,
    PH_RELEASE = 2'd3
  } phase_t;

  typedef struct packed {
    logic loadOp;
    logic commitPair;
    logic commitVote;
  } strobe_t;

endpackage

// File: rtl/bvc_ctrl.sv
module bvc_ctrl
  import bvc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    opValid,
  input  logic    pairEqual,
  input  logic    lendReq,
  input  logic    borrowGnt,
  output strobe_t strb,
  output logic    stall,
  output logic    borrowReq
);

  phase_t phase;
  logic   faultFlag;
  logic   detect;

  assign detect = (phase == PH_IDLE) && opValid && !lendReq && !pairEqual;

  always_comb begin
    strb.commitPair = (phase == PH_IDLE) && opValid && (lendReq || pairEqual);
    strb.commitVote = (phase == PH_VOTE) && borrowGnt;
    strb.loadOp     = ((phase == PH_IDLE) && !detect) || (phase == PH_RELEASE);
  end

  assign stall     = detect || faultFlag;
  assign borrowReq = (phase == PH_BORROW) || (phase == PH_VOTE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      faultFlag <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE:    if (detect)    phase <= PH_BORROW;
        PH_BORROW:  if (borrowGnt) phase <= PH_VOTE;
        PH_VOTE:    if (borrowGnt) phase <= PH_RELEASE;
        PH_RELEASE: phase <= PH_IDLE;
        default:    phase <= PH_IDLE;
      endcase
      if (detect)               faultFlag <= 1'b1;
      else if (strb.commitVote) faultFlag <= 1'b0;
    end
  end

endmodule

// File: rtl/bvc_datapath.sv
module bvc_datapath
  import bvc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  input  logic [DATA_W-1:0] resA,
  input  logic [DATA_W-1:0] resB,
  input  logic [DATA_W-1:0] resC,
  output logic              opValid,
  output logic [DATA_W-1:0] opOut,
  output logic              pairEqual,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              uncorrErr
);

  logic [DATA_W-1:0] voted;
  logic              voteOk;

  assign pairEqual = (resA == resB);

  for (genvar b = 0; b < DATA_W; b++) begin : g_vote
    assign voted[b] = (resA[b] & resB[b]) | (resA[b] & resC[b]) | (resB[b] & resC[b]);
  end

  assign voteOk = (resA == resB) || (resA == resC) || (resB == resC);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      opValid   <= 1'b0;
      opOut     <= '0;
      outValid  <= 1'b0;
      outData   <= '0;
      uncorrErr <= 1'b0;
    end else begin
      if (strb.loadOp) begin
        opValid <= inValid;
        opOut   <= inData;
      end
      outValid  <= strb.commitPair || (strb.commitVote && voteOk);
      uncorrErr <= strb.commitVote && !voteOk;
      if (strb.commitPair)               outData <= resA;
      else if (strb.commitVote && voteOk) outData <= voted;
    end
  end

endmodule

// File: rtl/borrow_vote_ctrl.sv
module borrow_vote_ctrl
  import bvc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [DATA_W-1:0] inData,
  output logic              stall,
  output logic [DATA_W-1:0] opOut,
  input  logic [DATA_W-1:0] resA,
  input  logic [DATA_W-1:0] resB,
  input  logic [DATA_W-1:0] resC,
  input  logic              lendReq,
  output logic              borrowReq,
  input  logic              borrowGnt,
  output logic              outValid,
  output logic [DATA_W-1:0] outData,
  output logic              uncorrErr
);

  strobe_t strb;
  logic    opValid;
  logic    pairEqual;

  bvc_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .pairEqual(pairEqual),
    .lendReq(lendReq), .borrowGnt(borrowGnt), .strb(strb),
    .stall(stall), .borrowReq(borrowReq)
  );

  bvc_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .inValid(inValid), .inData(inData),
    .resA(resA), .resB(resB), .resC(resC), .opValid(opValid), .opOut(opOut),
    .pairEqual(pairEqual), .outValid(outValid), .outData(outData),
    .uncorrErr(uncorrErr)
  );

endmodule

// File: rtl/bvc_checker.sv
module bvc_checker #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              stall,
  input logic              borrowReq,
  input logic              outValid,
  input logic              uncorrErr,
  input logic [DATA_W-1:0] opOut
);

  AST_UNCORR_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    uncorrErr |-> !outValid);                                   // R7
  AST_UNCORR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    uncorrErr |=> !uncorrErr);                                  // R7
  AST_BORROW_STALLS: assert property (@(posedge clk) disable iff (!rstN)
    borrowReq |-> stall);                                       // R4
  AST_OPERAND_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(opOut));                                  // R4
  AST_MISMATCH_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(borrowReq) |-> !outValid);                            // R3
  AST_RELEASE_UNSTALLS: assert property (@(posedge clk) disable iff (!rstN)
    $fell(borrowReq) |-> !stall);                               // R6

endmodule

bind borrow_vote_ctrl bvc_checker #(.DATA_W(DATA_W)) i_bvc_checker (
  .clk(clk), .rstN(rstN), .stall(stall), .borrowReq(borrowReq),
  .outValid(outValid), .uncorrErr(uncorrErr), .opOut(opOut)
);

// File: tb/test_borrow_vote_ctrl.sv
module test_borrow_vote_ctrl;

  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rstN;
  logic              inValid;
  logic [DATA_W-1:0] inData;
  logic              stall;
  logic [DATA_W-1:0] opOut;
  logic [DATA_W-1:0] resA, resB, resC;
  logic [DATA_W-1:0] maskA, maskB, maskC;
  logic              lendReq;
  logic              borrowReq;
  logic              borrowGnt;
  logic              outValid;
  logic [DATA_W-1:0] outData;
  logic              uncorrErr;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  assign resA = (opOut + 8'd1) ^ maskA;
  assign resB = (opOut + 8'd1) ^ maskB;
  assign resC = (opOut + 8'd1) ^ maskC;

  borrow_vote_ctrl #(.DATA_W(DATA_W)) i_borrow_vote_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inData(inData),
    .stall(stall), .opOut(opOut), .resA(resA), .resB(resB), .resC(resC),
    .lendReq(lendReq), .borrowReq(borrowReq), .borrowGnt(borrowGnt),
    .outValid(outValid), .outData(outData), .uncorrErr(uncorrErr)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    rstN = 1'b0; inValid = 1'b0; inData = '0; lendReq = 1'b0; borrowGnt = 1'b1;
    maskA = '0; maskB = '0; maskC = '0;
    tick(); tick();
    check("R1 outValid", int'(outValid), 0);
    check("R1 stall", int'(stall), 0);
    check("R1 borrowReq", int'(borrowReq), 0);
    check("R1 uncorrErr", int'(uncorrErr), 0);
    rstN = 1'b1;
    tick();
  endtask

  task automatic t_normal();
    inValid = 1'b1; inData = 8'h10;
    tick();
    check("R2 no stall", int'(stall), 0);
    inData = 8'h11;
    tick();
    check("R2 outValid", int'(outValid), 1);
    check("R2 outData", int'(outData), 'h11);
    inValid = 1'b0;
    tick();
    check("R2 back-to-back data", int'(outData), 'h12);
    tick();
  endtask

  task automatic t_fault_b();
    inValid = 1'b1; inData = 8'h20; maskB = 8'h80;
    tick();                                   // detect cycle
    check("R3 stall same cycle", int'(stall), 1);
    inData = 8'h30;
    tick();                                   // borrow cycle
    check("R3 mismatch blocked", int'(outValid), 0);
    check("R4 borrowReq", int'(borrowReq), 1);
    check("R4 operand frozen", int'(opOut), 'h20);
    tick();                                   // vote cycle
    check("R4 stall in vote", int'(stall), 1);
    tick();                                   // release cycle
    check("R5 voted commit", int'(outValid), 1);
    check("R5 voted data", int'(outData), 'h21);
    check("R6 borrow released", int'(borrowReq), 0);
    check("R8 mismatch ignored", int'(stall), 0);
    maskB = '0;
    tick();
    check("R6 next operand", int'(opOut), 'h30);
    check("R6 no commit in release", int'(outValid), 0);
    inValid = 1'b0;
    tick();
    check("R6 next commit", int'(outData), 'h31);
    tick();
  endtask

  task automatic t_uncorrectable();
    inValid = 1'b1; inData = 8'h40; maskA = 8'h01; maskB = 8'h02; maskC = 8'h04;
    tick();
    inValid = 1'b0;
    tick(); tick(); tick();
    check("R7 uncorrErr pulse", int'(uncorrErr), 1);
    check("R7 no commit", int'(outValid), 0);
    check("R7 data kept", int'(outData), 'h31);
    maskA = '0; maskB = '0; maskC = '0;
    tick();
    check("R7 pulse ends", int'(uncorrErr), 0);
    tick();
  endtask

  task automatic t_grant_wait();
    borrowGnt = 1'b0;
    inValid = 1'b1; inData = 8'h50; maskB = 8'h10;
    tick();
    inValid = 1'b0;
    tick(); tick(); tick();
    check("R4 wait for grant", int'(borrowReq), 1);
    check("R4 no commit waiting", int'(outValid), 0);
    borrowGnt = 1'b1;
    tick(); tick();
    check("R5 commit after grant", int'(outValid), 1);
    check("R5 data after grant", int'(outData), 'h51);
    maskB = '0;
    tick();
  endtask

  task automatic t_lend();
    lendReq = 1'b1; maskB = 8'h08;
    inValid = 1'b1; inData = 8'h60;
    tick();
    check("R9 no stall while lending", int'(stall), 0);
    inValid = 1'b0;
    tick();
    check("R9 commit unit A", int'(outValid), 1);
    check("R9 data unit A", int'(outData), 'h61);
    lendReq = 1'b0; maskB = '0;
    tick();
  endtask

  task automatic t_fault_a();
    maskA = 8'h20;
    inValid = 1'b1; inData = 8'h70;
    tick();
    check("R3 stall on A fault", int'(stall), 1);
    inValid = 1'b0;
    tick(); tick(); tick();
    check("R5 vote masks A", int'(outData), 'h71);
    maskA = '0;
    tick();
  endtask

  initial begin
    t_reset();
    t_normal();
    t_fault_b();
    t_uncorrectable();
    t_grant_wait();
    t_lend();
    t_fault_a();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (10000) @(posedge clk);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule